// File: doc/BRIEF.md
# Load-Linked Reservation Unit

This unit carries out the load-linked operation of a core with 64-bit registers. A request carries an effective address, a select between a 4-byte word and an 8-byte doubleword access, and a flag saying whether the core is in debug mode. The unit first checks that the address is naturally aligned for the chosen size.

If the address is misaligned, the unit raises an address-error-on-load pulse and does not touch memory. It copies the faulting address into a bad-address register, but only when the core is not in debug mode. If the address is aligned, the unit issues one read on a single-outstanding memory port and waits for the data. It then returns the value, sign-extended from bit 31 for a word access. At the same time it sets up a reservation: the address, the returned value and a valid bit. A store-conditional checker elsewhere in the core reads these outputs.

The unit accepts one request at a time. Address translation is treated as identity.

Top module: `linked_load_unit`

## Requirements
- R1: A word request (`reqDouble`=0) is misaligned when `reqAddr[1:0]` is nonzero. A doubleword request (`reqDouble`=1) is misaligned when `reqAddr[2:0]` is nonzero. A misaligned request makes `excAddrErr` high for exactly the one cycle after the request is accepted.
- R2: A misaligned request never asserts `memRdEn`, leaves `busy` low and produces no `done`.
- R3: On a misaligned request with `reqDebug`=0, `badAddr` takes the request address. With `reqDebug`=1, `badAddr` keeps its previous value.
- R4: An aligned request makes `memRdEn` high for exactly the one cycle after acceptance. In that cycle `memRdAddr` equals the request address and `memRdDouble` equals `reqDouble`. `busy` is high from that cycle until the completion cycle.
- R5: For a word access, `result` holds bits 31:0 of `memRdData`, sign-extended from bit 31 to 64 bits, and the upper input bits are ignored. For a doubleword access, `result` holds `memRdData` unchanged.
- R6: `memRdValid` is taken while `busy` is high. In the following cycle `done` is high for exactly one cycle, `result` is valid and `busy` is low.
- R7: When a load completes, `linkValid` becomes 1, `linkAddr` holds the request address and `linkValue` holds the returned `result`. These outputs are valid in the cycle in which `done` is high.
- R8: `linkClear` clears `linkValid` on the next cycle. If a completion happens in the same cycle as `linkClear`, the new reservation wins and `linkValid` stays 1.
- R9: A request presented while `busy` is high is ignored. It raises no fault, issues no read and does not change the reservation.
- R10: After reset, `busy`, `done`, `excAddrErr`, `memRdEn` and `linkValid` are 0, and `badAddr` is 0.
- R11: For any single request, `excAddrErr` and `done` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when not busy |
| reqAddr | input | ADDR_W | Effective address |
| reqDouble | input | 1 | 1 selects doubleword, 0 selects word |
| reqDebug | input | 1 | Core is in debug mode |
| linkClear | input | 1 | Drop the reservation |
| busy | output | 1 | A read is outstanding |
| done | output | 1 | One-cycle completion pulse |
| result | output | XLEN | Loaded value |
| excAddrErr | output | 1 | One-cycle address-error-on-load pulse |
| badAddr | output | ADDR_W | Last faulting address captured outside debug mode |
| memRdEn | output | 1 | One-cycle read request |
| memRdAddr | output | ADDR_W | Read address |
| memRdDouble | output | 1 | Read size, 1 for doubleword |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | XLEN | Read data |
| linkValid | output | 1 | Reservation held |
| linkAddr | output | ADDR_W | Reserved address |
| linkValue | output | XLEN | Reserved value |

## Verification
The alignment check is tried with every low-bit offset that breaks one size but not the other. For example, an address ending in 4 is legal for a word but faults for a doubleword, which separates the two mask widths. Word reads are driven with the data's bit 31 both set and clear, and with nonzero upper bits, so that sign extension is told apart from zero extension and from passing the input through. Faults are raised with and without debug mode to show that the bad-address capture is gated. A request made while a read is outstanding, and a clear that lands on the completion cycle, cover the two ordering cases.

// File: rtl/llru_pkg.sv
package llru_pkg;
  typedef struct packed {
    logic takeReq;   // aligned request accepted
    logic loadBad;   // misaligned request, capture address
    logic takeResp;  // read data accepted
  } llStrobes_t;
endpackage

// File: rtl/llru_ctrl.sv
module llru_ctrl
  import llru_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqDebug,
  input  logic       alignFault,
  input  logic       memRdValid,
  output llStrobes_t strb,
  output logic       busy,
  output logic       memRdEn,
  output logic       done,
  output logic       excAddrErr
);
  typedef enum logic {ST_IDLE, ST_WAIT} llState_t;
  llState_t state;
  logic accept;

  always_comb begin
    accept        = (state == ST_IDLE) && reqValid;
    strb.takeReq  = accept && !alignFault;
    strb.loadBad  = accept && alignFault && !reqDebug;
    strb.takeResp = (state == ST_WAIT) && memRdValid;
    busy          = (state == ST_WAIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      memRdEn    <= 1'b0;
      done       <= 1'b0;
      excAddrErr <= 1'b0;
    end else begin
      if (strb.takeReq)       state <= ST_WAIT;
      else if (strb.takeResp) state <= ST_IDLE;
      memRdEn    <= strb.takeReq;
      done       <= strb.takeResp;
      excAddrErr <= accept && alignFault;
    end
  end
endmodule

// File: rtl/llru_datapath.sv
module llru_datapath
  import llru_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int XLEN   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  llStrobes_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqDouble,
  input  logic [XLEN-1:0]   memRdData,
  input  logic              linkClear,
  output logic              alignFault,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              memRdDouble,
  output logic [ADDR_W-1:0] badAddr,
  output logic [XLEN-1:0]   result,
  output logic              linkValid,
  output logic [ADDR_W-1:0] linkAddr,
  output logic [XLEN-1:0]   linkValue
);
  localparam int WORD_W   = 32;
  localparam int WORD_LSB = $clog2(WORD_W / 8);
  localparam int DBL_LSB  = $clog2(XLEN / 8);

  logic [XLEN-1:0] wordExt;
  logic [XLEN-1:0] loaded;

  always_comb begin
    if (reqDouble) alignFault = |reqAddr[DBL_LSB-1:0];
    else           alignFault = |reqAddr[WORD_LSB-1:0];
  end

  generate
    if (XLEN > WORD_W) begin : g_ext
      assign wordExt = {{(XLEN-WORD_W){memRdData[WORD_W-1]}}, memRdData[WORD_W-1:0]};
    end else begin : g_noext
      assign wordExt = memRdData;
    end
  endgenerate

  assign loaded = memRdDouble ? memRdData : wordExt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memRdAddr   <= '0;
      memRdDouble <= 1'b0;
      badAddr     <= '0;
      result      <= '0;
      linkValid   <= 1'b0;
      linkAddr    <= '0;
      linkValue   <= '0;
    end else begin
      if (strb.takeReq) begin
        memRdAddr   <= reqAddr;
        memRdDouble <= reqDouble;
      end
      if (strb.loadBad) badAddr <= reqAddr;
      if (strb.takeResp) begin
        result    <= loaded;
        linkValue <= loaded;
        linkAddr  <= memRdAddr;
        linkValid <= 1'b1;
      end else if (linkClear) begin
        linkValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/linked_load_unit.sv
module linked_load_unit
  import llru_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int XLEN   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqDouble,
  input  logic              reqDebug,
  input  logic              linkClear,
  output logic              busy,
  output logic              done,
  output logic [XLEN-1:0]   result,
  output logic              excAddrErr,
  output logic [ADDR_W-1:0] badAddr,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              memRdDouble,
  input  logic              memRdValid,
  input  logic [XLEN-1:0]   memRdData,
  output logic              linkValid,
  output logic [ADDR_W-1:0] linkAddr,
  output logic [XLEN-1:0]   linkValue
);
  llStrobes_t strb;
  logic       alignFault;

  llru_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqDebug(reqDebug),
    .alignFault(alignFault), .memRdValid(memRdValid), .strb(strb),
    .busy(busy), .memRdEn(memRdEn), .done(done), .excAddrErr(excAddrErr)
  );

  llru_datapath #(.ADDR_W(ADDR_W), .XLEN(XLEN)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqDouble(reqDouble), .memRdData(memRdData), .linkClear(linkClear),
    .alignFault(alignFault), .memRdAddr(memRdAddr), .memRdDouble(memRdDouble),
    .badAddr(badAddr), .result(result), .linkValid(linkValid),
    .linkAddr(linkAddr), .linkValue(linkValue)
  );
endmodule

// File: rtl/llru_checker.sv
module llru_checker #(
  parameter int ADDR_W = 32,
  parameter int XLEN   = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqDebug,
  input logic              busy,
  input logic              done,
  input logic              excAddrErr,
  input logic [ADDR_W-1:0] badAddr,
  input logic              memRdEn,
  input logic              linkValid,
  input logic [XLEN-1:0]   result,
  input logic [XLEN-1:0]   linkValue
);
  p_no_read_on_fault_r2: assert property (@(posedge clk) disable iff (!rstN)
    excAddrErr |-> !memRdEn && !busy);

  p_debug_freeze_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && reqDebug) |=> $stable(badAddr));

  p_read_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> busy);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_link_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> linkValid && (linkValue == result));

  p_exclusive_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(done && excAddrErr));
endmodule

bind linked_load_unit llru_checker #(.ADDR_W(ADDR_W), .XLEN(XLEN)) u_chk (.*);

// File: tb/test_linked_load_unit.sv
module test_linked_load_unit;
  localparam int ADDR_W = 32;
  localparam int XLEN   = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqDouble = 1'b0, reqDebug = 1'b0, linkClear = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic memRdValid = 1'b0;
  logic [XLEN-1:0] memRdData = '0;
  logic busy, done, excAddrErr, memRdEn, memRdDouble, linkValid;
  logic [XLEN-1:0] result, linkValue;
  logic [ADDR_W-1:0] badAddr, memRdAddr, linkAddr;

  int errors = 0;
  int checks = 0;
  logic [ADDR_W-1:0] expBad = '0;

  always #4 clk = ~clk;  // 125 MHz

  linked_load_unit #(.ADDR_W(ADDR_W), .XLEN(XLEN)) i_linked_load_unit (.*);

  task automatic check(input logic ok, input string tag, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] expResult(input logic dbl, input logic [XLEN-1:0] d);
    if (dbl) return d;
    return {{32{d[31]}}, d[31:0]};
  endfunction

  // One request; aligned ones get memory data one cycle after the read pulse.
  task automatic doLoad(input logic [ADDR_W-1:0] addr, input logic dbl, input logic dbg,
                        input logic [XLEN-1:0] data);
    logic fault;
    logic [XLEN-1:0] er;
    fault = dbl ? (addr[2:0] != 0) : (addr[1:0] != 0);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqDouble = dbl; reqDebug = dbg;
    @(negedge clk);
    reqValid = 1'b0;
    if (fault) begin
      if (!dbg) expBad = addr;
      check(excAddrErr == 1'b1, "R1 fault pulse", XLEN'(excAddrErr), 1);
      check(!memRdEn && !busy, "R2 no read on fault", XLEN'({memRdEn, busy}), 0);
      check(badAddr == expBad, "R3 bad address", XLEN'(badAddr), XLEN'(expBad));
      @(negedge clk);
      check(!excAddrErr && !done && !memRdEn, "R11 fault single pulse, no done",
            XLEN'({excAddrErr, done, memRdEn}), 0);
    end else begin
      check(excAddrErr == 1'b0, "R1 no fault when aligned", XLEN'(excAddrErr), 0);
      check(memRdEn && busy, "R4 read issued", XLEN'({memRdEn, busy}), 3);
      check(memRdAddr == addr && memRdDouble == dbl, "R4 read addr/size",
            XLEN'({memRdAddr, memRdDouble}), XLEN'({addr, dbl}));
      memRdValid = 1'b1; memRdData = data;
      @(negedge clk);
      memRdValid = 1'b0;
      er = expResult(dbl, data);
      check(done && !busy && !memRdEn, "R6 done pulse", XLEN'({done, busy, memRdEn}), 4);
      check(result == er, "R5 result extension", result, er);
      check(linkValid && linkAddr == addr && linkValue == er, "R7 reservation",
            linkValue, er);
      @(negedge clk);
      check(!done, "R6 done single cycle", XLEN'(done), 0);
    end
  endtask

  task automatic testReset();
    check(!busy && !done && !excAddrErr && !memRdEn && !linkValid && badAddr == 0,
          "R10 reset state", XLEN'({busy, done, excAddrErr, memRdEn, linkValid}), 0);
  endtask

  task automatic testAlign();
    doLoad(32'h0000_1001, 1'b0, 1'b0, '0);               // R1 word offset 1
    doLoad(32'h0000_2002, 1'b0, 1'b0, '0);               // R1 word offset 2
    doLoad(32'h0000_3004, 1'b1, 1'b0, '0);               // R1 dbl offset 4
    doLoad(32'h0000_4004, 1'b0, 1'b0, 64'hDEADBEEF_12345678); // word ok at 4
    doLoad(32'h0000_5008, 1'b1, 1'b0, 64'h8123_4567_89AB_CDEF);
  endtask

  task automatic testDebug();
    doLoad(32'h0000_6003, 1'b0, 1'b1, '0);   // R3 frozen in debug
    doLoad(32'h0000_7006, 1'b1, 1'b1, '0);
    doLoad(32'h0000_8005, 1'b1, 1'b0, '0);   // R3 captured again
  endtask

  task automatic testSignExt();
    doLoad(32'h0000_9000, 1'b0, 1'b0, 64'h0000_0000_8000_1234); // R5 negative
    doLoad(32'h0000_A00C, 1'b0, 1'b0, 64'hFFFF_FFFF_7FFF_0001); // R5 positive
  endtask

  task automatic testBusyIgnore();
    logic [ADDR_W-1:0] prevBad;
    prevBad = badAddr;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 32'h0000_B000; reqDouble = 1'b1; reqDebug = 1'b0;
    @(negedge clk);
    reqAddr = 32'h0000_C001; reqDouble = 1'b0;   // R9 misaligned while busy
    @(negedge clk);
    reqValid = 1'b0;
    check(!excAddrErr && !memRdEn && busy && badAddr == prevBad, "R9 ignored while busy",
          XLEN'({excAddrErr, memRdEn, busy}), 1);
    memRdValid = 1'b1; memRdData = 64'h0123_4567_89AB_CDEF;
    @(negedge clk);
    memRdValid = 1'b0;
    check(done && linkAddr == 32'h0000_B000, "R9 original request kept",
          XLEN'(linkAddr), 64'hB000);
    @(negedge clk);
  endtask

  task automatic testClear();
    @(negedge clk);
    linkClear = 1'b1;
    @(negedge clk);
    linkClear = 1'b0;
    check(!linkValid, "R8 clear drops reservation", XLEN'(linkValid), 0);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 32'h0000_D010; reqDouble = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    memRdValid = 1'b1; memRdData = 64'h5; linkClear = 1'b1;
    @(negedge clk);
    memRdValid = 1'b0; linkClear = 1'b0;
    check(linkValid && done, "R8 completion wins over clear", XLEN'(linkValid), 1);
    @(negedge clk);
    check(linkValid, "R8 reservation held after", XLEN'(linkValid), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testAlign();
    testDebug();
    testSignExt();
    testBusyIgnore();
    testClear();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule